// File: doc/BRIEF.md
# Row-Hit-First DRAM Request Scheduler

This block keeps a small pool of pending memory requests, each holding a read/write flag, a bank, a row and a column. Each cycle it nominates one of them to be serviced next. It remembers which row is open in every bank. In row-hit-first mode it nominates a request that hits an open row ahead of one that would need a row change. Among requests of equal standing it takes the oldest. In oldest-first mode it ignores row hits. Requests that a timing window currently forbids are passed over, and the next oldest candidate is considered instead.

Writes are held back while any read is waiting, so reads see lower latency. Once the number of queued writes reaches a high-water mark, only writes are nominated until the count falls below the mark. Two spacing rules are enforced. A read must wait a minimum number of cycles after a granted write. Two row opens in the same bank must be a minimum row-cycle apart. The block does not drive DRAM commands. It reports the chosen slot index, the request fields, and whether a row open is needed. The downstream command engine accepts the nomination with a handshake.

Both edges are valid/ready streams. A request is stored on a cycle where `req_valid` and `req_ready` are both high. `req_ready` falls only when every slot is occupied. A nomination is consumed on a cycle where `gnt_valid` and `gnt_ready` are both high. While `gnt_ready` is low, nothing leaves the pool and no open-row or timing state changes. The offered nomination is re-evaluated every cycle, so it may change when new requests arrive or timing windows expire.

Top module: `frs_sched`

## Requirements
- R1: After reset the pool is empty: `req_ready` is 1 and `gnt_valid` is 0, and every bank is closed.
- R2: With `fcfs_mode` = 1, the oldest eligible request is nominated even when a younger request hits an open row.
- R3: With `fcfs_mode` = 0, an eligible request whose row equals the open row of its bank is nominated ahead of any request needing a row change, and among such hits the oldest wins; with no hit, the oldest eligible request wins.
- R4: A request that is blocked by a timing window is skipped and the next oldest eligible request is nominated in the same cycle.
- R5: A write (`req_write` = 1) is not nominated while any read (`req_write` = 0) is queued, unless the high-water condition of R6 holds.
- R6: While the number of queued writes is at least `WR_HI`, only writes are nominated.
- R7: A read is nominated no earlier than `T_WTR` cycles after the cycle in which a write was accepted; if nothing else blocks it, it is accepted exactly `T_WTR` cycles later.
- R8: Two accepted nominations that need a row open in the same bank are at least `T_RC` cycles apart; a request blocked only by this window is accepted exactly `T_RC` cycles after the earlier open.
- R9: `gnt_need_act` is 1 when the bank of the nominated request is closed or has a different row open, and 0 when that row is already open. Accepting a nomination leaves its row open in its bank.
- R10: A request is stored in the lowest-numbered free slot, and `gnt_idx` reports that slot. `req_ready` is 0 exactly when all `NQ` slots are occupied.
- R11: While `gnt_ready` is 0 and no request arrives, the same nomination stays offered. An accepted entry leaves the pool, so `gnt_valid` is 0 once the pool is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fcfs_mode | input | 1 | 1 = oldest-first, 0 = row-hit-first |
| req_valid | input | 1 | Incoming request valid |
| req_ready | output | 1 | A free slot exists |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| gnt_valid | output | 1 | A nomination is offered |
| gnt_ready | input | 1 | Downstream accepts the nomination |
| gnt_idx | output | clog2(NQ) | Slot index of the nominated request |
| gnt_need_act | output | 1 | Nominated request needs a row open |
| gnt_write | output | 1 | Nominated request is a write |
| gnt_bank | output | BANK_W | Bank of the nominated request |
| gnt_row | output | ROW_W | Row of the nominated request |
| gnt_col | output | COL_W | Column of the nominated request |

## Verification
Assertions check four properties on every cycle:
- The write-to-read gap and the per-bank row-cycle gap, each using a counter of its own that is separate from the blocking timers.
- The rule that writes are held back behind queued reads, and that only writes are nominated while the high-water mark is reached.
- That every accepted slot is occupied.
- That every stored request lands in its slot.

The ordering policies can only be shown by the bench scenarios. These cover hits overtaking older misses in one mode and not in the other, and a blocked request being overtaken and then accepted on the exact cycle its window closes. They also cover the read-write interleaving around the high-water mark and slot allocation when the pool is full.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int BANK_W = 2;
  parameter int ROW_W  = 8;
  parameter int COL_W  = 6;

  typedef struct packed {
    logic              wr;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } sreq_t;
endpackage

// File: rtl/sched_queue.sv
module sched_queue
  import sched_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int AGE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  enq_valid,
  output logic                  enq_ready,
  input  sreq_t                 enq_ent,
  input  logic                  del_valid,
  input  logic [$clog2(NQ)-1:0] del_idx,
  output logic [NQ-1:0]         vld,
  output sreq_t                 ents    [NQ],
  output logic [AGE_W-1:0]      elapsed [NQ]
);
  localparam int IW = $clog2(NQ);

  logic [NQ-1:0]    vld_q;
  sreq_t            ent_q [NQ];
  logic [AGE_W-1:0] age_q [NQ];
  logic [AGE_W-1:0] ctr_q;
  logic [IW-1:0]    slot;
  logic             has_free;
  logic             enq_fire;

  // lowest free slot wins
  always_comb begin
    has_free = 1'b0;
    slot     = '0;
    for (int i = NQ - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        has_free = 1'b1;
        slot     = IW'(i);
      end
    end
  end

  assign enq_ready = has_free;
  assign enq_fire  = enq_valid && has_free;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      ctr_q <= '0;
      for (int i = 0; i < NQ; i++) begin
        ent_q[i] <= '0;
        age_q[i] <= '0;
      end
    end else begin
      if (del_valid) vld_q[del_idx] <= 1'b0;
      if (enq_fire) begin
        vld_q[slot] <= 1'b1;
        ent_q[slot] <= enq_ent;
        age_q[slot] <= ctr_q;
        ctr_q       <= ctr_q + 1'b1;
      end
    end
  end

  // wrap-safe age: distance from the tag counter
  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      elapsed[i] = ctr_q - age_q[i];
      ents[i]    = ent_q[i];
    end
  end
  assign vld = vld_q;

  assert_grant_live_R11: assert property (@(posedge clk) disable iff (!rst_n)
    del_valid |-> vld_q[del_idx]);

  assert_enq_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    enq_fire |=> vld_q[$past(slot)]);
endmodule

// File: rtl/sched_banks.sv
module sched_banks
  import sched_pkg::*;
#(
  parameter int T_RC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              upd_act,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [2**BANK_W-1:0] open_vld,
  output logic [ROW_W-1:0]  open_row [2**BANK_W],
  output logic [2**BANK_W-1:0] rc_busy
);
  localparam int NB   = 2**BANK_W;
  localparam int RC_W = $clog2(T_RC) + 1;
  localparam logic [RC_W-1:0] RC_LOAD = RC_W'(T_RC - 1);
  localparam int SW   = $clog2(T_RC + 1) + 1;
  localparam logic [SW-1:0] RC_LIM = SW'(T_RC);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic            sel;
    logic [RC_W-1:0] rc_q;
    logic [SW-1:0]   since_q;

    assign sel        = upd && (upd_bank == BANK_W'(b));
    assign rc_busy[b] = (rc_q != '0);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        open_vld[b] <= 1'b0;
        open_row[b] <= '0;
        rc_q        <= '0;
      end else begin
        if (sel) begin
          open_vld[b] <= 1'b1;
          open_row[b] <= upd_row;
        end
        if (sel && upd_act)  rc_q <= RC_LOAD;
        else if (rc_q != '0) rc_q <= rc_q - 1'b1;
      end
    end

    // independent distance counter for the spacing check
    always_ff @(posedge clk) begin
      if (!rst_n)                  since_q <= RC_LIM;
      else if (sel && upd_act)     since_q <= SW'(1);
      else if (since_q < RC_LIM)   since_q <= since_q + 1'b1;
    end

    assert_rc_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && upd_act) |-> (since_q >= RC_LIM));
  end
endmodule

// File: rtl/sched_pick.sv
module sched_pick
  import sched_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int AGE_W = 16
) (
  input  logic [NQ-1:0]         vld,
  input  logic [NQ-1:0]         is_wr,
  input  logic [BANK_W-1:0]     bk      [NQ],
  input  logic [ROW_W-1:0]      rw      [NQ],
  input  logic [AGE_W-1:0]      elapsed [NQ],
  input  logic [2**BANK_W-1:0]  open_vld,
  input  logic [ROW_W-1:0]      open_row [2**BANK_W],
  input  logic [2**BANK_W-1:0]  rc_busy,
  input  logic                  wtr_busy,
  input  logic                  allow_rd,
  input  logic                  allow_wr,
  input  logic                  fcfs_mode,
  output logic                  sel_valid,
  output logic [$clog2(NQ)-1:0] sel_idx,
  output logic                  sel_act
);
  localparam int IW = $clog2(NQ);

  logic [NQ-1:0]    need_act;
  logic [NQ-1:0]    cand;
  logic             any_v, hit_v;
  logic [IW-1:0]    any_i, hit_i;
  logic [AGE_W-1:0] any_a, hit_a;

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      need_act[i] = !open_vld[bk[i]] || (open_row[bk[i]] != rw[i]);
      cand[i]     = vld[i]
                  && (is_wr[i] ? allow_wr : (allow_rd && !wtr_busy))
                  && !(need_act[i] && rc_busy[bk[i]]);
    end
  end

  // oldest overall and oldest hit; ascending scan with strict compare keeps lower index on ties
  always_comb begin
    any_v = 1'b0; any_i = '0; any_a = '0;
    hit_v = 1'b0; hit_i = '0; hit_a = '0;
    for (int i = 0; i < NQ; i++) begin
      if (cand[i] && (!any_v || elapsed[i] > any_a)) begin
        any_v = 1'b1; any_i = IW'(i); any_a = elapsed[i];
      end
      if (cand[i] && !need_act[i] && (!hit_v || elapsed[i] > hit_a)) begin
        hit_v = 1'b1; hit_i = IW'(i); hit_a = elapsed[i];
      end
    end
  end

  assign sel_valid = any_v;
  assign sel_idx   = (!fcfs_mode && hit_v) ? hit_i : any_i;
  assign sel_act   = need_act[sel_idx];
endmodule

// File: rtl/frs_sched.sv
module frs_sched
  import sched_pkg::*;
#(
  parameter int NQ    = 8,
  parameter int AGE_W = 16,
  parameter int T_WTR = 4,
  parameter int T_RC  = 6,
  parameter int WR_HI = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fcfs_mode,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [BANK_W-1:0]     req_bank,
  input  logic [ROW_W-1:0]      req_row,
  input  logic [COL_W-1:0]      req_col,
  output logic                  gnt_valid,
  input  logic                  gnt_ready,
  output logic [$clog2(NQ)-1:0] gnt_idx,
  output logic                  gnt_need_act,
  output logic                  gnt_write,
  output logic [BANK_W-1:0]     gnt_bank,
  output logic [ROW_W-1:0]      gnt_row,
  output logic [COL_W-1:0]      gnt_col
);
  localparam int NB    = 2**BANK_W;
  localparam int CW    = $clog2(NQ + 1);
  localparam logic [CW-1:0] HI = CW'(WR_HI);
  localparam int WTR_W = $clog2(T_WTR) + 1;
  localparam logic [WTR_W-1:0] WTR_LOAD = WTR_W'(T_WTR - 1);
  localparam int SW    = $clog2(T_WTR + 1) + 1;
  localparam logic [SW-1:0] WTR_LIM = SW'(T_WTR);

  sreq_t            in_ent;
  sreq_t            ents    [NQ];
  logic [AGE_W-1:0] elapsed [NQ];
  logic [NQ-1:0]    vld, is_wr;
  logic [BANK_W-1:0] bk [NQ];
  logic [ROW_W-1:0]  rw [NQ];
  logic [NB-1:0]    open_vld, rc_busy;
  logic [ROW_W-1:0] open_row [NB];
  logic             fire, rd_pend, drain, wtr_busy;
  logic [CW-1:0]    wr_cnt;
  logic [WTR_W-1:0] wtr_q;
  logic [SW-1:0]    since_wr_q;
  sreq_t            cur;

  assign in_ent = '{wr: req_write, bank: req_bank, row: req_row, col: req_col};

  sched_queue #(.NQ(NQ), .AGE_W(AGE_W)) u_queue (
    .clk, .rst_n,
    .enq_valid (req_valid), .enq_ready (req_ready), .enq_ent (in_ent),
    .del_valid (fire), .del_idx (gnt_idx),
    .vld, .ents, .elapsed
  );

  always_comb begin
    rd_pend = 1'b0;
    wr_cnt  = '0;
    for (int i = 0; i < NQ; i++) begin
      is_wr[i] = ents[i].wr;
      bk[i]    = ents[i].bank;
      rw[i]    = ents[i].row;
      rd_pend  = rd_pend | (vld[i] & ~ents[i].wr);
      wr_cnt   = wr_cnt + CW'(vld[i] & ents[i].wr);
    end
  end

  assign drain    = (wr_cnt >= HI);
  assign wtr_busy = (wtr_q != '0);

  sched_pick #(.NQ(NQ), .AGE_W(AGE_W)) u_pick (
    .vld, .is_wr, .bk, .rw, .elapsed, .open_vld, .open_row, .rc_busy,
    .wtr_busy, .allow_rd (!drain), .allow_wr (drain || !rd_pend), .fcfs_mode,
    .sel_valid (gnt_valid), .sel_idx (gnt_idx), .sel_act (gnt_need_act)
  );

  assign cur       = ents[gnt_idx];
  assign gnt_write = cur.wr;
  assign gnt_bank  = cur.bank;
  assign gnt_row   = cur.row;
  assign gnt_col   = cur.col;
  assign fire      = gnt_valid && gnt_ready;

  sched_banks #(.T_RC(T_RC)) u_banks (
    .clk, .rst_n,
    .upd (fire), .upd_act (gnt_need_act), .upd_bank (cur.bank), .upd_row (cur.row),
    .open_vld, .open_row, .rc_busy
  );

  always_ff @(posedge clk) begin
    if (!rst_n)               wtr_q <= '0;
    else if (fire && cur.wr)  wtr_q <= WTR_LOAD;
    else if (wtr_q != '0)     wtr_q <= wtr_q - 1'b1;
  end

  // separate distance counter used only by the gap check
  always_ff @(posedge clk) begin
    if (!rst_n)                     since_wr_q <= WTR_LIM;
    else if (fire && cur.wr)        since_wr_q <= SW'(1);
    else if (since_wr_q < WTR_LIM)  since_wr_q <= since_wr_q + 1'b1;
  end

  assert_wtr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !gnt_write) |-> (since_wr_q >= WTR_LIM));

  assert_write_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && gnt_write) |-> (!rd_pend || drain));

  assert_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && drain) |-> gnt_write);
endmodule

// File: tb/tb_frs_sched.sv
module tb_frs_sched;
  import sched_pkg::*;

  localparam int NQ = 8;
  localparam int T_WTR = 4;
  localparam int T_RC = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fcfs_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_write = 1'b0;
  logic [BANK_W-1:0] req_bank = '0;
  logic [ROW_W-1:0]  req_row = '0;
  logic [COL_W-1:0]  req_col = '0;
  logic gnt_valid;
  logic gnt_ready = 1'b0;
  logic [$clog2(NQ)-1:0] gnt_idx;
  logic gnt_need_act, gnt_write;
  logic [BANK_W-1:0] gnt_bank;
  logic [ROW_W-1:0]  gnt_row;
  logic [COL_W-1:0]  gnt_col;

  always #4 clk = ~clk;

  frs_sched #(.NQ(NQ), .T_WTR(T_WTR), .T_RC(T_RC), .WR_HI(3)) dut (.*);

  typedef struct {
    int    col;
    int    wr;
    int    act;
    int    idx;
    string tag;
  } exp_t;

  exp_t sb[$];
  int   fire_log[$];
  int   n_chk = 0;
  int   n_fail = 0;
  int   cyc = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc++;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_gnt(int col, int wr, int act, int idx, string tag);
    exp_t e;
    e.col = col; e.wr = wr; e.act = act; e.idx = idx; e.tag = tag;
    sb.push_back(e);
  endtask

  // monitor: sample between the driving negedge and the next posedge
  always @(negedge clk) begin
    #2;
    if (rst_n && gnt_valid && gnt_ready) begin
      fire_log.push_back(cyc);
      if (sb.size() == 0) begin
        chk("R11 unexpected grant col", int'(gnt_col), -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.tag, " col"}, int'(gnt_col), e.col);
        chk({e.tag, " write"}, int'(gnt_write), e.wr);
        chk({e.tag, " need_act R9"}, int'(gnt_need_act), e.act);
        if (e.idx >= 0) chk({e.tag, " idx R10"}, int'(gnt_idx), e.idx);
      end
    end
  end

  task automatic enq(int wr, int bank, int row, int col);
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr[0];
    req_bank  = BANK_W'(bank);
    req_row   = ROW_W'(row);
    req_col   = COL_W'(col);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic release_and_drain();
    @(negedge clk);
    gnt_ready = 1'b1;
    while (sb.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
  end

  initial begin
    int p;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready after reset", int'(req_ready), 1);
    chk("R1 gnt_valid after reset", int'(gnt_valid), 0);

    // oldest-first, all banks closed at start (R2, R9, R11)
    fcfs_mode = 1'b1;
    expect_gnt(1, 0, 1, 0, "R2 A");
    expect_gnt(2, 0, 1, 1, "R2 B");
    expect_gnt(3, 0, 0, 2, "R9 C hit");
    enq(0, 0, 1, 1);
    enq(0, 1, 2, 2);
    enq(0, 0, 1, 3);
    p = fire_log.size();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #2;
      chk("R11 held valid", int'(gnt_valid), 1);
      chk("R11 held idx", int'(gnt_idx), 0);
    end
    chk("R11 no accept while not ready", fire_log.size(), p);
    release_and_drain();

    // older miss still goes first in oldest-first mode
    gnt_ready = 1'b0;
    expect_gnt(4, 0, 1, 0, "R2 older miss first");
    expect_gnt(5, 0, 0, 1, "R2 younger hit second");
    enq(0, 1, 7, 4);
    enq(0, 0, 1, 5);
    release_and_drain();

    // row-hit-first: hits overtake the older miss, oldest hit leads (R3)
    gnt_ready = 1'b0;
    fcfs_mode = 1'b0;
    expect_gnt(7, 0, 0, 1, "R3 oldest hit");
    expect_gnt(8, 0, 0, 2, "R3 next hit");
    expect_gnt(6, 0, 1, 0, "R3 miss last");
    enq(0, 0, 9, 6);
    enq(0, 1, 7, 7);
    enq(0, 1, 7, 8);
    release_and_drain();

    // blocked by row-cycle window: skipped, then taken on the exact cycle (R4, R8)
    gnt_ready = 1'b0;
    expect_gnt(9, 0, 1, 0, "R4 first open");
    expect_gnt(11, 0, 1, 2, "R4 skip to other bank");
    expect_gnt(10, 0, 1, 1, "R8 blocked open");
    enq(0, 2, 3, 9);
    enq(0, 2, 4, 10);
    enq(0, 3, 1, 11);
    p = fire_log.size();
    release_and_drain();
    chk("R8 row-cycle gap", fire_log[p+2] - fire_log[p], T_RC);
    chk("R4 skipped request one cycle later", fire_log[p+1] - fire_log[p], 1);

    // write held behind read (R5)
    gnt_ready = 1'b0;
    expect_gnt(13, 0, 0, 1, "R5 read first");
    expect_gnt(12, 1, 0, 0, "R5 write after");
    enq(1, 0, 9, 12);
    enq(0, 1, 7, 13);
    release_and_drain();

    // read after write waits the gap (R7)
    expect_gnt(14, 1, 0, 0, "R7 write");
    expect_gnt(15, 0, 0, 1, "R7 read");
    p = fire_log.size();
    enq(1, 0, 9, 14);
    enq(0, 1, 7, 15);
    while (sb.size() > 0) @(negedge clk);
    repeat (10) @(negedge clk);
    chk("R7 write-to-read gap", fire_log[p+1] - fire_log[p], T_WTR);

    // high-water drain interleaves with the waiting read (R6)
    gnt_ready = 1'b0;
    expect_gnt(17, 1, 0, 1, "R6 drain write");
    expect_gnt(16, 0, 0, 0, "R6 read below mark");
    expect_gnt(18, 1, 0, 2, "R6 write b");
    expect_gnt(19, 1, 0, 3, "R6 write c");
    enq(0, 1, 7, 16);
    enq(1, 1, 7, 17);
    enq(1, 1, 7, 18);
    enq(1, 1, 7, 19);
    p = fire_log.size();
    release_and_drain();
    chk("R6 R7 gap before read", fire_log[p+1] - fire_log[p], T_WTR);

    // fill the pool, slot allocation and back-pressure (R10, R11)
    gnt_ready = 1'b0;
    for (int k = 0; k < NQ; k++) begin
      expect_gnt(20 + k, 0, 0, k, "R10 slot order");
      enq(0, 3, 1, 20 + k);
    end
    @(negedge clk);
    chk("R10 req_ready when full", int'(req_ready), 0);
    release_and_drain();
    chk("R11 pool empty after accepts", int'(gnt_valid), 0);
    chk("R10 req_ready after drain", int'(req_ready), 1);
    chk("scoreboard empty", sb.size(), 0);
    report();
  end
endmodule